// File: doc/BRIEF.md
# Non-Preemptive Frame Request Arbiter

This block sits between a set of transfer request lines and the memory-side engine that moves frames of data. Each request line belongs to one packet, numbered from 0 upward. A request is taken only if its packet is enabled when the request arrives. Once taken, the request is held in a sticky pending register until the arbiter starts a frame for it. The arbiter starts at most one frame at a time. It picks the lowest-numbered pending packet, and the running frame ends only when the engine reports that it has finished.

A request that was taken before software disabled its packet still starts its frame later. A busy bit that reads low therefore does not prove that memory is quiet. For that reason the block also has a global hold input. While hold is high, no frame starts and no new bus request goes out, but incoming requests are still taken and kept pending. A bus-busy output stays high while any bus request is still waiting for its acknowledge. Software can raise hold, wait for bus-busy to clear, and then use memory safely.

Top module: `frame_arb`

## Requirements
- R1: A request on `req_i[i]` is taken at a clock edge only if `pkt_en_i[i]` is high at that edge. A request seen while its enable is low produces no grant and no busy.
- R2: When no frame is running, hold is low and at least one request is pending, the next edge produces a one-cycle one-hot pulse on `grant_o` (bit i for packet i). From that same cycle `busy_o` shows the same bit.
- R3: Among pending packets, the lowest index is granted first. The remaining packets follow in ascending order.
- R4: `busy_o` keeps its bit until the edge at which `frame_done_i` is high, and no other packet starts before then. After the frame ends, the next grant comes one edge later. `frame_done_i` while idle has no effect.
- R5: A request taken while its packet was enabled still starts its frame after the enable is dropped.
- R6: While `hold_i` is high, no grant is issued and `bus_req_o` does not rise. Requests are still taken and launch after hold falls.
- R7: While a frame runs and hold is low, `bus_req_o` rises one edge after `busy_o` (and again after each acknowledge). It stays high until an edge with `bus_ack_i` high, even if hold rises meanwhile. `bus_busy_o` is high exactly while a bus request is outstanding.
- R8: A new request for a packet that arrives at the same edge that grants that packet stays pending and is granted again later.
- R9: After reset, `grant_o`, `busy_o`, `bus_req_o` and `bus_busy_o` are all zero and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NREQ | Transfer request per packet |
| pkt_en_i | input | NREQ | Enable per packet, checked when a request arrives |
| frame_done_i | input | 1 | Strobe ending the running frame |
| hold_i | input | 1 | Global hold of launches and bus requests |
| bus_ack_i | input | 1 | Acknowledge for the outstanding bus request |
| grant_o | output | NREQ | One-cycle one-hot frame start pulse |
| busy_o | output | NREQ | One-hot packet whose frame is running |
| bus_req_o | output | 1 | Bus request toward memory |
| bus_busy_o | output | 1 | A bus transaction is outstanding |

## Verification
The bench builds the arbiter with NREQ=4. At that size it can sweep every combination of the 16 request patterns and the 16 enable patterns. For each combination it checks the full ascending grant order against the masked set, computed with lowest-set-bit arithmetic, and it drops the enables after acceptance on half of the patterns. Directed sequences then cover hold during pending requests, a bus request left outstanding across a rise of hold, re-requests at the grant edge, and stray done strobes.

// File: rtl/frame_arb.sv
module frame_arb #(
  parameter int NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  input  logic [NREQ-1:0] pkt_en_i,
  input  logic            frame_done_i,
  input  logic            hold_i,
  input  logic            bus_ack_i,
  output logic [NREQ-1:0] grant_o,
  output logic [NREQ-1:0] busy_o,
  output logic            bus_req_o,
  output logic            bus_busy_o
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NREQ-1:0] pend, pick;
  logic [IW-1:0]   cur_idx, win_idx;
  logic            active, launch;

  always_comb begin
    pick    = '0;
    win_idx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  assign launch     = !active && !hold_i && (|pend);
  assign busy_o     = active ? (NREQ'(1) << cur_idx) : '0;
  assign bus_busy_o = bus_req_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      grant_o   <= '0;
      active    <= 1'b0;
      cur_idx   <= '0;
      bus_req_o <= 1'b0;
    end else begin
      pend    <= (pend & ~({NREQ{launch}} & pick)) | (req_i & pkt_en_i);
      grant_o <= {NREQ{launch}} & pick;
      if (launch) begin
        active  <= 1'b1;
        cur_idx <= win_idx;
      end else if (frame_done_i) begin
        active  <= 1'b0;
      end
      if (bus_req_o && bus_ack_i)
        bus_req_o <= 1'b0;
      else if (!bus_req_o && active && !hold_i && !frame_done_i)
        bus_req_o <= 1'b1;
    end
  end
endmodule

module frame_arb_chk #(
  parameter int NREQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_done_i,
  input logic            hold_i,
  input logic            bus_ack_i,
  input logic [NREQ-1:0] grant_o,
  input logic [NREQ-1:0] busy_o,
  input logic            bus_req_o,
  input logic [NREQ-1:0] pend
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  assert_busy_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_o));
  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (((grant_o - NREQ'(1)) & $past(pend)) == '0));
  assert_no_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o != '0 && !frame_done_i) |=> (busy_o == $past(busy_o)));
  assert_hold_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> !$past(hold_i));
  assert_hold_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> !$past(hold_i));
  assert_bus_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> bus_req_o);
endmodule

bind frame_arb frame_arb_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done_i), .hold_i(hold_i),
  .bus_ack_i(bus_ack_i), .grant_o(grant_o), .busy_o(busy_o),
  .bus_req_o(bus_req_o), .pend(pend)
);

// File: tb/sim_frame_arb.sv
`timescale 1ns/1ps
module sim_frame_arb;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req, en;
  logic done, hold, ack;
  logic [N-1:0] grant, busy;
  logic breq, bbusy;
  int total = 0, bad = 0;
  bit finished = 0;

  frame_arb #(.NREQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .pkt_en_i(en), .frame_done_i(done),
    .hold_i(hold), .bus_ack_i(ack), .grant_o(grant), .busy_o(busy),
    .bus_req_o(breq), .bus_busy_o(bbusy)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_frame();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req = '0; en = '0; done = 0; hold = 0; ack = 0;
    tick(); tick();
    rst_n = 1'b1; tick();
    chk(grant == 0 && busy == 0 && !breq && !bbusy, "R9 reset", {grant, busy, breq, bbusy}, 0);
    tick();
    chk(grant == 0 && busy == 0, "R9 nothing pending", {grant, busy}, 0);

    ack = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        logic [N-1:0] s, low;
        s = N'(p & e);
        req = N'(p); en = N'(e);
        tick();
        req = '0;
        if (p % 2 == 1) en = '0;
        while (s != 0) begin
          low = s & (~s + 1'b1);
          tick();
          chk(grant == low && busy == low, "R2 R3 R5 grant order", {grant, busy}, {low, low});
          tick(); tick();
          chk(grant == 0 && busy == low, "R4 frame held", {grant, busy}, {4'h0, low});
          finish_frame();
          chk(busy == 0, "R4 frame ends", busy, 0);
          s = s & ~low;
        end
        tick(); tick();
        chk(grant == 0 && busy == 0, "R1 masked requests ignored", {grant, busy}, 0);
        tick(); tick();
      end
    end
    ack = 1'b0;
    tick(); tick();

    hold = 1'b1; en = '1; req = 4'b1010;
    tick(); req = '0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(grant == 0 && busy == 0 && !breq, "R6 hold blocks launch", {grant, busy, breq}, 0);
    end
    hold = 1'b0;
    tick();
    chk(grant == 4'b0010, "R6 launch after hold", grant, 4'b0010);
    ack = 1'b1; finish_frame();
    tick();
    chk(grant == 4'b1000, "R6 second pending after hold", grant, 4'b1000);
    finish_frame(); ack = 1'b0;
    tick(); tick();

    req = 4'b0100;
    tick(); req = '0;
    tick();
    chk(busy == 4'b0100 && !breq, "R7 busy before bus req", {busy, breq}, {4'b0100, 1'b0});
    tick();
    chk(breq && bbusy, "R7 bus req raised", {breq, bbusy}, 2'b11);
    hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(breq && bbusy, "R7 outstanding across hold", {breq, bbusy}, 2'b11);
    end
    ack = 1'b1; tick(); ack = 1'b0;
    chk(!breq && !bbusy, "R7 cleared by ack", {breq, bbusy}, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!breq, "R6 no new bus req under hold", breq, 0);
    end
    hold = 1'b0;
    tick();
    chk(breq && bbusy, "R7 bus req after hold", {breq, bbusy}, 2'b11);
    ack = 1'b1; finish_frame(); ack = 1'b0;
    tick(); tick();
    chk(!breq && busy == 0, "R7 idle after frame", {breq, busy}, 0);

    req = 4'b0001;
    tick();
    tick();
    chk(grant == 4'b0001, "R8 first grant", grant, 4'b0001);
    req = '0;
    ack = 1'b1; finish_frame();
    tick();
    chk(grant == 4'b0001, "R8 re-request granted again", grant, 4'b0001);
    finish_frame(); ack = 1'b0;

    done = 1'b1; tick(); tick(); done = 1'b0;
    req = 4'b0100; tick(); req = '0;
    tick();
    chk(grant == 4'b0100 && busy == 4'b0100, "R4 stray done ignored", {grant, busy}, 8'h44);
    tick(); tick();
    chk(busy == 4'b0100, "R4 busy held after stray done", busy, 4'b0100);
    ack = 1'b1; finish_frame();
    tick(); tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule